// File: doc/BRIEF.md
# Protected System Clock Control Unit

This block holds two 8-bit clock configuration registers behind a write gate. From them it produces a divided system clock enable, a stop flag, an oscillator drive-strength flag, and the clock source selects for the timer group and the serial group. Software reaches the registers through a small synchronous bus with an address, a write strobe, write data and combinational read data. A register write takes effect only while the separate `wr_en_i` input is high.

The system clock is never gated. A free-running counter pulses `sys_ce_o` for one cycle out of every N cycles, where N is 1, 2, 4 or 16 as set by the control register. N is fixed at a parameter value (default 8) whenever `div_override_i` is high. A new ratio is latched only when an enable pulse fires, so a ratio change never shortens the interval in progress. While stop mode is set, `sys_ce_o` stays low until `wake_i` clears the stop bit.

Hardware raises the drive-strength bit in two cases. The first is when stop mode is entered while the core runs from the main clock. The second is when the main clock is switched off while the core runs in low-speed mode.

Top module: `sys_clk_ctrl`

## Requirements
- R1: After reset the control register (address 0) reads 0x20, the peripheral select register (address 1) reads 0x03, and `sys_ce_o` is high on every cycle.
- R2: With `div_override_i` low, control bits 7:6 set the enable period: 00 gives every cycle, 01 every 2nd cycle, 10 every 4th cycle and 11 every 16th cycle.
- R3: While `div_override_i` is high, the enable period is OVR_DIV cycles (default 8), whatever bits 7:6 hold.
- R4: A write with `bus_we_i` high while `wr_en_i` is low changes no register.
- R5: Writing 1 to control bit 0 sets stop mode: `stop_o` is high and `sys_ce_o` stays low. A `wake_i` pulse clears bit 0 on the next edge and takes priority over a write in the same cycle.
- R6: Writing 1 to control bit 0 while bit 0 is 0 and `low_speed_i` is low sets bit 5 (`drive_hi_o`), whatever value is written to bit 5. With `low_speed_i` high, bit 5 takes the written value.
- R7: While both `low_speed_i` and `main_off_i` are high, bit 5 is set to 1 on every edge, and a write of 0 to it has no effect.
- R8: Control bits 4:1 and peripheral select bits 7:2 always read 0.
- R9: Peripheral select bit 0 drives `tmr_sel_f1_o` and bit 1 drives `sio_sel_f1_o`.
- R10: A change of ratio takes effect only at the next enable pulse. No interval between pulses is ever shorter than the smaller of the old and new periods.
- R11: Read data shows the current register contents whatever the level of `wr_en_i`.
- R12: Addresses other than 0 and 1 read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | ADDR_W | Register address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data (combinational) |
| wr_en_i | input | 1 | Write gate; writes are accepted only while high |
| div_override_i | input | 1 | Forces the fixed OVR_DIV ratio |
| low_speed_i | input | 1 | Core runs in low-speed mode |
| main_off_i | input | 1 | Main oscillator is switched off |
| wake_i | input | 1 | Clears stop mode |
| sys_ce_o | output | 1 | Divided system clock enable |
| stop_o | output | 1 | Stop mode flag |
| drive_hi_o | output | 1 | Oscillator drive strength high |
| tmr_sel_f1_o | output | 1 | Timer clock source: 1 selects f1, 0 selects f2 |
| sio_sel_f1_o | output | 1 | Serial clock source: 1 selects f1SIO, 0 selects f2SIO |

## Verification
The hardest case to reach is a ratio change that lands in the middle of a long interval. The stimulus sets the divide-by-16 ratio, waits a few cycles into the interval, rewrites the ratio to divide-by-2, and then rewrites it again before the boundary. This shows whether the old interval runs to its full length. The forced drive-strength paths need a set order of events. The stimulus first clears bit 5 and then enters stop mode, once with `low_speed_i` low and once with it high. It also holds `main_off_i` high while a write tries to clear bit 5. Every cycle is compared with a behavioural model.

// File: rtl/sys_clk_pkg.sv
package sys_clk_pkg;

  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    DIV_1  = 2'b00,
    DIV_2  = 2'b01,
    DIV_4  = 2'b10,
    DIV_16 = 2'b11
  } div_sel_e;

  typedef struct packed {
    div_sel_e    div;
    logic        drv_hi;
    logic [3:0]  rsvd;
    logic        stop;
  } ctrl_reg_t;

  typedef struct packed {
    logic [5:0]  rsvd;
    logic        sio_f1;
    logic        tmr_f1;
  } psel_reg_t;

  localparam ctrl_reg_t CTRL_RST = '{div: DIV_1, drv_hi: 1'b1, rsvd: 4'h0, stop: 1'b0};
  localparam psel_reg_t PSEL_RST = '{rsvd: 6'h0, sio_f1: 1'b1, tmr_f1: 1'b1};

  function automatic int unsigned div_ratio(div_sel_e sel);
    case (sel)
      DIV_1:   return 1;
      DIV_2:   return 2;
      DIV_4:   return 4;
      default: return 16;
    endcase
  endfunction

endpackage

// File: rtl/sck_ctrl_reg.sv
module sck_ctrl_reg
  import sys_clk_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_i,
  input  div_sel_e  wr_div_i,
  input  logic      wr_drv_i,
  input  logic      wr_stop_i,
  input  logic      low_speed_i,
  input  logic      main_off_i,
  input  logic      wake_i,
  output ctrl_reg_t ctrl_o
);

  ctrl_reg_t q, d;
  logic      stop_entry;

  // stop entered while running from the main clock
  assign stop_entry = wr_i && wr_stop_i && !q.stop && !low_speed_i;

  always_comb begin
    d = q;
    if (wr_i) begin
      d.div    = wr_div_i;
      d.drv_hi = wr_drv_i | stop_entry;
      d.stop   = wr_stop_i;
    end
    if (low_speed_i && main_off_i) d.drv_hi = 1'b1;
    if (wake_i)                    d.stop   = 1'b0;
    d.rsvd = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= CTRL_RST;
    else         q <= d;
  end

  assign ctrl_o = q;

endmodule

// File: rtl/sck_psel_reg.sv
module sck_psel_reg
  import sys_clk_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_i,
  input  logic      wr_tmr_i,
  input  logic      wr_sio_i,
  output psel_reg_t psel_o
);

  psel_reg_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= PSEL_RST;
    end else if (wr_i) begin
      q.tmr_f1 <= wr_tmr_i;
      q.sio_f1 <= wr_sio_i;
      q.rsvd   <= '0;
    end
  end

  assign psel_o = q;

endmodule

// File: rtl/sck_div_gen.sv
module sck_div_gen
  import sys_clk_pkg::*;
#(
  parameter int unsigned MAX_DIV = 16,
  parameter int unsigned OVR_DIV = 8
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     stop_i,
  input  logic     override_i,
  input  div_sel_e div_sel_i,
  output logic     ce_o
);

  localparam int unsigned CNT_W = $clog2(MAX_DIV);
  localparam int unsigned RAT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [RAT_W-1:0] ratio_q, ratio_new;
  logic             last;

  always_comb begin
    if (override_i) ratio_new = RAT_W'(OVR_DIV);
    else            ratio_new = RAT_W'(div_ratio(div_sel_i));
  end

  assign last = ({1'b0, cnt_q} == (ratio_q - RAT_W'(1)));

  // ratio is reloaded only on a pulse boundary or while stopped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ratio_q <= RAT_W'(1);
    end else if (stop_i || last) begin
      cnt_q   <= '0;
      ratio_q <= ratio_new;
    end else begin
      cnt_q   <= cnt_q + CNT_W'(1);
    end
  end

  assign ce_o = !stop_i && last;

endmodule

// File: rtl/sys_clk_ctrl.sv
module sys_clk_ctrl
  import sys_clk_pkg::*;
#(
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned CTRL_ADDR = 0,
  parameter int unsigned PSEL_ADDR = 1,
  parameter int unsigned MAX_DIV   = 16,
  parameter int unsigned OVR_DIV   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  input  logic              wr_en_i,
  input  logic              div_override_i,
  input  logic              low_speed_i,
  input  logic              main_off_i,
  input  logic              wake_i,
  output logic              sys_ce_o,
  output logic              stop_o,
  output logic              drive_hi_o,
  output logic              tmr_sel_f1_o,
  output logic              sio_sel_f1_o
);

  ctrl_reg_t ctrl;
  psel_reg_t psel;
  logic      acc, sel_ctrl, sel_psel;

  assign acc      = bus_we_i && wr_en_i;
  assign sel_ctrl = (bus_addr_i == ADDR_W'(CTRL_ADDR));
  assign sel_psel = (bus_addr_i == ADDR_W'(PSEL_ADDR));

  sck_ctrl_reg u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (acc && sel_ctrl),
    .wr_div_i    (div_sel_e'(bus_wdata_i[7:6])),
    .wr_drv_i    (bus_wdata_i[5]),
    .wr_stop_i   (bus_wdata_i[0]),
    .low_speed_i (low_speed_i),
    .main_off_i  (main_off_i),
    .wake_i      (wake_i),
    .ctrl_o      (ctrl)
  );

  sck_psel_reg u_psel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (acc && sel_psel),
    .wr_tmr_i (bus_wdata_i[0]),
    .wr_sio_i (bus_wdata_i[1]),
    .psel_o   (psel)
  );

  sck_div_gen #(
    .MAX_DIV (MAX_DIV),
    .OVR_DIV (OVR_DIV)
  ) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stop_i     (ctrl.stop),
    .override_i (div_override_i),
    .div_sel_i  (ctrl.div),
    .ce_o       (sys_ce_o)
  );

  always_comb begin
    if (sel_ctrl)      bus_rdata_o = ctrl;
    else if (sel_psel) bus_rdata_o = psel;
    else               bus_rdata_o = '0;
  end

  assign stop_o       = ctrl.stop;
  assign drive_hi_o   = ctrl.drv_hi;
  assign tmr_sel_f1_o = psel.tmr_f1;
  assign sio_sel_f1_o = psel.sio_f1;

endmodule

// File: rtl/sys_clk_ctrl_chk.sv
module sys_clk_ctrl_chk #(
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_we_i,
  input logic [7:0]        bus_wdata_i,
  input logic [7:0]        bus_rdata_o,
  input logic              wr_en_i,
  input logic              div_override_i,
  input logic              low_speed_i,
  input logic              main_off_i,
  input logic              wake_i,
  input logic              sys_ce_o,
  input logic              stop_o,
  input logic              drive_hi_o,
  input logic              tmr_sel_f1_o,
  input logic              sio_sel_f1_o
);

  assert_stop_no_ce_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> !sys_ce_o);

  assert_wake_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> !stop_o);

  assert_gated_stop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !wake_i) |=> $stable(stop_o));

  assert_gated_psel_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(tmr_sel_f1_o) && $stable(sio_sel_f1_o)));

  assert_stop_entry_drv_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && wr_en_i && bus_addr_i == '0 && bus_wdata_i[0] && !stop_o && !low_speed_i)
      |=> drive_hi_o);

  assert_main_off_drv_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_speed_i && main_off_i) |=> drive_hi_o);

  assert_rsvd_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == ADDR_W'(0)) |-> (bus_rdata_o[4:1] == 4'h0));

  assert_unmapped_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i > ADDR_W'(1)) |-> (bus_rdata_o == 8'h00));

endmodule

bind sys_clk_ctrl sys_clk_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sys_clk_ctrl_test.sv
module sys_clk_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       wr_en = 1'b0, ovr = 1'b0, low = 1'b0, moff = 1'b0, wake = 1'b0;
  logic       ce, stp, drv, tmr, sio;

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  sys_clk_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .wr_en_i(wr_en),
    .div_override_i(ovr), .low_speed_i(low), .main_off_i(moff), .wake_i(wake),
    .sys_ce_o(ce), .stop_o(stp), .drive_hi_o(drv), .tmr_sel_f1_o(tmr), .sio_sel_f1_o(sio)
  );

  // behavioural reference model
  int   m_div, m_cnt, m_ratio;
  bit   m_drv, m_stop, m_tmr, m_sio;

  function automatic int ratio_of(int d);
    if (ovr) return 8;
    case (d)
      0: return 1;
      1: return 2;
      2: return 4;
      default: return 16;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div = 0; m_drv = 1; m_stop = 0; m_tmr = 1; m_sio = 1;
      m_cnt = 0; m_ratio = 1;
    end else begin
      int  nr;
      bit  old_stop;
      nr = ratio_of(m_div);
      old_stop = m_stop;
      if (m_stop || m_cnt == m_ratio - 1) begin
        m_cnt = 0; m_ratio = nr;
      end else begin
        m_cnt++;
      end
      if (we && wr_en && addr == 0) begin
        m_div  = wdata[7:6];
        m_drv  = wdata[5] || (wdata[0] && !old_stop && !low);
        m_stop = wdata[0];
      end
      if (we && wr_en && addr == 1) begin
        m_tmr = wdata[0]; m_sio = wdata[1];
      end
      if (low && moff) m_drv = 1;
      if (wake) m_stop = 0;
    end
  end

  function automatic logic [7:0] exp_rdata();
    case (addr)
      2'd0: return {m_div[1:0], m_drv, 4'b0000, m_stop};
      2'd1: return {6'b000000, m_sio, m_tmr};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(cur_req, "rdata", rdata, exp_rdata());
      check(cur_req, "sys_ce", ce, int'(!m_stop && m_cnt == m_ratio - 1));
      check(cur_req, "stop", stp, m_stop);
      check(cur_req, "drive_hi", drv, m_drv);
      check(cur_req, "tmr_sel", tmr, m_tmr);
      check(cur_req, "sio_sel", sio, m_sio);
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    step(1);
    we = 1'b0;
  endtask

  int ce_cnt;

  initial begin
    step(2);
    rst_n = 1'b1;
    // R1 reset values and undivided enable
    cur_req = "R1";
    addr = 2'd0; step(3);
    addr = 2'd1; step(2);
    addr = 2'd0;

    // R4 gated write
    cur_req = "R4";
    wr_en = 1'b0;
    wr(2'd0, 8'hC1); step(2);
    wr(2'd1, 8'h00); addr = 2'd1; step(2);

    // R8 reserved bits
    cur_req = "R8";
    wr_en = 1'b1;
    wr(2'd0, 8'h1E); addr = 2'd0; step(2);
    wr(2'd1, 8'hFC); addr = 2'd1; step(2);

    // R2 each ratio
    cur_req = "R2";
    for (int s = 0; s < 4; s++) begin
      wr(2'd0, 8'(s << 6)); addr = 2'd0; step(40);
    end
    // explicit pulse count at divide by 4
    wr(2'd0, 8'h80); step(20);
    ce_cnt = 0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk); if (ce) ce_cnt++;
    end
    #1;
    check("R2", "div4 pulses in 32", ce_cnt, 8);

    // R10 mid-interval ratio change
    cur_req = "R10";
    wr(2'd0, 8'hC0); step(20);
    step(3);
    wr(2'd0, 8'h40); step(4);
    wr(2'd0, 8'h80); step(40);
    wr(2'd0, 8'h00); step(3);
    wr(2'd0, 8'hC0); step(40);

    // R3 override
    cur_req = "R3";
    ovr = 1'b1; step(30);
    wr(2'd0, 8'h40); step(30);
    wr(2'd0, 8'h00); step(30);
    ovr = 1'b0; step(20);

    // R6 stop entry from main clock forces drive high
    cur_req = "R6";
    low = 1'b0;
    wr(2'd0, 8'h40); step(2);
    wr(2'd0, 8'h41); step(10);
    // R5 stop holds enable low, wake clears
    cur_req = "R5";
    step(10);
    wake = 1'b1; step(1); wake = 1'b0; step(10);
    // wake beats a write in the same cycle
    addr = 2'd0; wdata = 8'h01; we = 1'b1; wake = 1'b1;
    step(1);
    we = 1'b0; wake = 1'b0; step(5);
    // R6 low-speed entry keeps written drive value
    cur_req = "R6";
    low = 1'b1;
    wr(2'd0, 8'h01); step(6);
    wake = 1'b1; step(1); wake = 1'b0; step(4);

    // R7 main clock off in low speed
    cur_req = "R7";
    wr(2'd0, 8'h00); step(2);
    moff = 1'b1; step(3);
    wr(2'd0, 8'h00); step(3);
    moff = 1'b0; wr(2'd0, 8'h00); step(3);
    low = 1'b0; step(2);

    // R9 peripheral selects
    cur_req = "R9";
    addr = 2'd1;
    wr(2'd1, 8'h00); step(2);
    wr(2'd1, 8'h01); step(2);
    wr(2'd1, 8'h02); step(2);
    wr(2'd1, 8'hFF); step(2);

    // R11 reads with gate closed
    cur_req = "R11";
    wr_en = 1'b0;
    addr = 2'd0; step(3);
    addr = 2'd1; step(3);

    // R12 unmapped addresses
    cur_req = "R12";
    wr_en = 1'b1;
    wr(2'd2, 8'hFF); addr = 2'd2; step(2);
    wr(2'd3, 8'hFF); addr = 2'd3; step(2);
    addr = 2'd0; step(2);
    addr = 2'd1; step(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule